// File: doc/BRIEF.md
# Sampled Coverage Ratio Estimator

This block is used when two rasters that both carry depth are merged into one. For one output pixel it estimates the share of the pixel area where the front raster's surface is closer to the viewer than the back raster's surface. Each raster supplies four corner depths for the pixel. The block receives them as two byte beats per corner, low byte first.

At each corner the block forms the signed difference back minus front. Adding neighbouring corner differences gives four edge samples. Adding two opposite edge sums gives one centre sample. Each of the nine samples has a power-of-two weight. The estimate is the sum of the weights of the samples at which the front raster is nearer. The result is a 5-bit value in sixteenths, ranging from 0 to 16.

With the estimate the block also returns one flag per corner that names the raster with the smaller depth there. A later stage uses these flags to pick the merged depth.

Top module: `cover_est`

## Requirements
- R1: A pixel enters as two beats on consecutive cycles. In the low beat `lo_stb` is 1 and lane k of each byte bus (bits k*8+7..k*8) carries the low byte of corner k. In the next cycle `hi_stb` is 1 and the same lanes carry the high bytes. The borrow from the low byte is carried into the high byte, so for example 0x0100 against 0x00FF compares correctly. `lo_stb` and `hi_stb` are never 1 in the same cycle.
- R2: Corner depths are 16-bit two's complement values. The corner difference is back minus front and is exact over the full range, with no wrap. For example, back 32767 against front -32768 is positive. The front raster counts as nearer at a sample when that sample's value is zero or more. `near_bk[k]` is 1 exactly when back depth k is strictly less than front depth k.
- R3: Corners are numbered 0 top-left, 1 top-right, 2 bottom-right, 3 bottom-left. Edge sample k is the sum of corner differences k and (k+1) mod 4.
- R4: The centre sample is the sum of two opposite edge sums. This equals the sum of all four corner differences.
- R5: `cov` counts in sixteenths. Each corner sample where the front is nearer adds 1, each such edge sample adds 2, and the centre sample adds 4. As a result `cov` never exceeds 16, and its bit 0 equals the parity of the number of front-nearer corners.
- R6: If all four corners favour the front, `cov` is exactly 16. If all four favour the back, `cov` is exactly 0.
- R7: `out_vld` is a one-cycle pulse. It is high in the cycle that begins four rising edges after the edge that samples the high beat. `cov` and `near_bk` change only together with that pulse and hold their values until the next one.
- R8: A new pixel may start in the cycle right after a high beat, giving one pixel every two cycles. Each result depends only on its own pixel.
- R9: While `rst` is high at a clock edge, `out_vld`, `cov` and `near_bk` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_stb | input | 1 | Low-byte beat present |
| hi_stb | input | 1 | High-byte beat present; completes the pixel |
| front_byte | input | 32 | Front raster corner depth bytes, lane k = corner k |
| back_byte | input | 32 | Back raster corner depth bytes, lane k = corner k |
| out_vld | output | 1 | Result pulse |
| cov | output | 5 | Front coverage in sixteenths, 0..16 |
| near_bk | output | 4 | Per corner: 1 when the back depth is smaller |

## Verification
The unanimous patterns (front nearer everywhere, back nearer everywhere, all ties) test the plain depth-buffer extremes and the tie rule. A single winning corner, a checkerboard of equal and opposite differences, and a case where only the centre sum tips toward the front each isolate one sample class: corner, edge or centre. Depth pairs that straddle a byte boundary test the borrow path between beats, and pairs at opposite ends of the 16-bit range test that the difference does not wrap. Random pixels follow, some spread narrowly so that ties and cancellations are frequent and some spread widely, sent both with gaps and back to back, to test the weight sum and that results from neighbouring pixels stay separate.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int NC        = 4;
  localparam int W_CORNER  = 1;
  localparam int W_EDGE    = 2;
  localparam int W_CENTRE  = 4;
  localparam int COV_ONE   = NC * W_CORNER + NC * W_EDGE + W_CENTRE;
  localparam int COV_W     = $clog2(COV_ONE) + 1;

  // neighbour corner going clockwise
  function automatic int nxt(input int k);
    return (k + 1) % NC;
  endfunction
endpackage

// File: rtl/cse_serial_addsub.sv
// Two-beat adder/subtractor. One flip-flop keeps the low-beat carry and,
// after the high beat, the sign of the exact (HW+1)-bit high result.
module cse_serial_addsub #(
  parameter int LW  = 8,
  parameter int HW  = 8,
  parameter bit SUB = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lo_en,
  input  logic          hi_en,
  input  logic [LW-1:0] a_lo,
  input  logic [LW-1:0] b_lo,
  input  logic [HW-1:0] a_hi,
  input  logic [HW-1:0] b_hi,
  output logic [LW-1:0] sum_lo,
  output logic [HW:0]   sum_hi,
  output logic          cs
);
  logic [LW-1:0] b_lo_op;
  logic [LW:0]   lo_res;
  logic [HW:0]   a_ext, b_ext, b_hi_op, hi_res;

  always_comb begin
    b_lo_op = SUB ? ~b_lo : b_lo;
    lo_res  = {1'b0, a_lo} + {1'b0, b_lo_op} + {{LW{1'b0}}, SUB};
    a_ext   = {a_hi[HW-1], a_hi};
    b_ext   = {b_hi[HW-1], b_hi};
    b_hi_op = SUB ? ~b_ext : b_ext;
    hi_res  = a_ext + b_hi_op + {{HW{1'b0}}, cs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_lo <= '0;
      sum_hi <= '0;
      cs     <= 1'b0;
    end else if (lo_en) begin
      sum_lo <= lo_res[LW-1:0];
      cs     <= lo_res[LW];
    end else if (hi_en) begin
      sum_hi <= hi_res;
      cs     <= hi_res[HW];
    end
  end

  // R1: a high beat always uses the carry left by the beat just before it
  p_hi_after_lo_r1: assert property (@(posedge clk) disable iff (rst)
    hi_en |-> $past(lo_en));
endmodule

// File: rtl/cse_sign_pipe.sv
module cse_sign_pipe #(
  parameter int W     = 4,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] st;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st[0] <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= {st[DEPTH-2:0], d};
      end
    end
  endgenerate

  assign q = st[DEPTH-1];
endmodule

// File: rtl/cse_weight_sum.sv
module cse_weight_sum
  import cse_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [NC-1:0]    c_sg,
  input  logic [NC-1:0]    e_sg,
  input  logic             m_sg,
  output logic             out_vld,
  output logic [COV_W-1:0] cov,
  output logic [NC-1:0]    near_bk
);
  logic [COV_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NC; k++) begin
      if (!c_sg[k]) acc = acc + COV_W'(W_CORNER);
      if (!e_sg[k]) acc = acc + COV_W'(W_EDGE);
    end
    if (!m_sg) acc = acc + COV_W'(W_CENTRE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      cov     <= '0;
      near_bk <= '0;
    end else begin
      out_vld <= en;
      if (en) begin
        cov     <= acc;
        near_bk <= c_sg;
      end
    end
  end

  p_cov_range_r5: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> cov <= COV_W'(COV_ONE));
  p_cov_parity_r5: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> cov[0] == ^(~near_bk));
  p_all_front_r6: assert property (@(posedge clk) disable iff (rst)
    (out_vld && near_bk == '0) |-> cov == COV_W'(COV_ONE));
  p_all_back_r6: assert property (@(posedge clk) disable iff (rst)
    (out_vld && near_bk == '1) |-> cov == '0);
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!out_vld && cov == '0 && near_bk == '0));
endmodule

// File: rtl/cover_est.sv
module cover_est
  import cse_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter bit CENTRE_TB = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lo_stb,
  input  logic                 hi_stb,
  input  logic [NC*LANE_W-1:0] front_byte,
  input  logic [NC*LANE_W-1:0] back_byte,
  output logic                 out_vld,
  output logic [COV_W-1:0]     cov,
  output logic [NC-1:0]        near_bk
);
  localparam int HW_C = LANE_W;
  localparam int HW_E = HW_C + 1;
  localparam int HW_M = HW_E + 1;
  // opposite edge pair feeding the centre sum
  localparam int PA = CENTRE_TB ? 0 : 1;
  localparam int PB = CENTRE_TB ? 2 : 3;

  logic v1, v2, v3;
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= hi_stb;
      v2 <= v1;
      v3 <= v2;
    end
  end

  logic [LANE_W-1:0] c_lo [NC];
  logic [HW_C:0]     c_hi [NC];
  logic [NC-1:0]     c_sg;
  logic [LANE_W-1:0] e_lo_maybe_unused [NC];
  logic [HW_E:0]     e_hi_maybe_unused [NC];
  logic [NC-1:0]     e_sg;
  logic [LANE_W-1:0] m_lo_unused;
  logic [HW_M:0]     m_hi_unused;
  logic              m_sg;
  logic [NC-1:0]     c_sg_d, e_sg_d;

  generate
    for (genvar k = 0; k < NC; k++) begin : g_corner
      cse_serial_addsub #(.LW(LANE_W), .HW(HW_C), .SUB(1'b1)) u_sub (
        .clk   (clk),
        .rst   (rst),
        .lo_en (lo_stb),
        .hi_en (hi_stb),
        .a_lo  (back_byte[k*LANE_W +: LANE_W]),
        .b_lo  (front_byte[k*LANE_W +: LANE_W]),
        .a_hi  (back_byte[k*LANE_W +: LANE_W]),
        .b_hi  (front_byte[k*LANE_W +: LANE_W]),
        .sum_lo(c_lo[k]),
        .sum_hi(c_hi[k]),
        .cs    (c_sg[k])
      );

      // R2: corner sign equals an exact signed compare of the two beats
      p_corner_sign_r2: assert property (@(posedge clk) disable iff (rst)
        hi_stb |=> c_sg[k] ==
          ($signed({$past(back_byte[k*LANE_W +: LANE_W]),
                    $past(back_byte[k*LANE_W +: LANE_W], 2)}) <
           $signed({$past(front_byte[k*LANE_W +: LANE_W]),
                    $past(front_byte[k*LANE_W +: LANE_W], 2)})));
    end

    for (genvar k = 0; k < NC; k++) begin : g_edge
      cse_serial_addsub #(.LW(LANE_W), .HW(HW_E), .SUB(1'b0)) u_add (
        .clk   (clk),
        .rst   (rst),
        .lo_en (hi_stb),
        .hi_en (v1),
        .a_lo  (c_lo[k]),
        .b_lo  (c_lo[nxt(k)]),
        .a_hi  (c_hi[k]),
        .b_hi  (c_hi[nxt(k)]),
        .sum_lo(e_lo_maybe_unused[k]),
        .sum_hi(e_hi_maybe_unused[k]),
        .cs    (e_sg[k])
      );
    end
  endgenerate

  cse_serial_addsub #(.LW(LANE_W), .HW(HW_M), .SUB(1'b0)) u_centre (
    .clk   (clk),
    .rst   (rst),
    .lo_en (v1),
    .hi_en (v2),
    .a_lo  (e_lo_maybe_unused[PA]),
    .b_lo  (e_lo_maybe_unused[PB]),
    .a_hi  (e_hi_maybe_unused[PA]),
    .b_hi  (e_hi_maybe_unused[PB]),
    .sum_lo(m_lo_unused),
    .sum_hi(m_hi_unused),
    .cs    (m_sg)
  );

  cse_sign_pipe #(.W(NC), .DEPTH(2)) u_cdly (
    .clk(clk), .rst(rst), .d(c_sg), .q(c_sg_d)
  );
  cse_sign_pipe #(.W(NC), .DEPTH(1)) u_edly (
    .clk(clk), .rst(rst), .d(e_sg), .q(e_sg_d)
  );

  cse_weight_sum u_wsum (
    .clk    (clk),
    .rst    (rst),
    .en     (v3),
    .c_sg   (c_sg_d),
    .e_sg   (e_sg_d),
    .m_sg   (m_sg),
    .out_vld(out_vld),
    .cov    (cov),
    .near_bk(near_bk)
  );

  p_hi_follows_lo_r1: assert property (@(posedge clk) disable iff (rst)
    lo_stb |=> hi_stb);
  p_beats_apart_r1: assert property (@(posedge clk) disable iff (rst)
    !(lo_stb && hi_stb));
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(hi_stb, 4));
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(cov) && $stable(near_bk)));
endmodule

// File: tb/sim_cover_est.sv
module sim_cover_est;
  logic        clk = 1'b0;
  logic        rst;
  logic        lo_stb, hi_stb;
  logic [31:0] front_byte, back_byte;
  logic        out_vld;
  logic [4:0]  cov;
  logic [3:0]  near_bk;

  typedef struct {
    int    cov;
    int    near;
    int    stamp;
    string tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  bit   finished = 1'b0;

  cover_est u0 (
    .clk(clk), .rst(rst), .lo_stb(lo_stb), .hi_stb(hi_stb),
    .front_byte(front_byte), .back_byte(back_byte),
    .out_vld(out_vld), .cov(cov), .near_bk(near_bk)
  );

  initial forever #4 clk = ~clk;
  initial forever begin
    @(posedge clk);
    cyc = cyc + 1;
  end

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input logic [63:0] fv, input logic [63:0] bv,
                       output int c, output int n);
    int d[4];
    int e;
    int m;
    c = 0; n = 0; m = 0;
    for (int k = 0; k < 4; k++) begin
      d[k] = int'($signed(bv[k*16 +: 16])) - int'($signed(fv[k*16 +: 16]));
      m += d[k];
    end
    for (int k = 0; k < 4; k++) begin
      e = d[k] + d[(k+1)%4];
      if (d[k] >= 0) c += 1; else n |= (1 << k);
      if (e >= 0) c += 2;
    end
    if (m >= 0) c += 4;
  endtask

  task automatic send(input logic [63:0] fv, input logic [63:0] bv, input string tag);
    exp_t x;
    model(fv, bv, x.cov, x.near);
    x.tag = tag;
    @(negedge clk);
    lo_stb = 1'b1; hi_stb = 1'b0;
    for (int k = 0; k < 4; k++) begin
      front_byte[k*8 +: 8] = fv[k*16 +: 8];
      back_byte[k*8 +: 8]  = bv[k*16 +: 8];
    end
    @(negedge clk);
    lo_stb = 1'b0; hi_stb = 1'b1;
    for (int k = 0; k < 4; k++) begin
      front_byte[k*8 +: 8] = fv[k*16+8 +: 8];
      back_byte[k*8 +: 8]  = bv[k*16+8 +: 8];
    end
    x.stamp = cyc;
    q.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lo_stb = 1'b0; hi_stb = 1'b0;
    end
  endtask

  function automatic logic [63:0] pack4(input int a, input int b, input int c, input int d);
    return {16'(d), 16'(c), 16'(b), 16'(a)};
  endfunction

  // monitor: pops expected results as the design produces them
  initial forever begin
    @(negedge clk);
    if (rst !== 1'b1 && out_vld === 1'b1) begin
      if (q.size() == 0) chk("R7", "unexpected out_vld", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "cov", int'(cov), e.cov);
        chk(e.tag, "near_bk", int'(near_bk), e.near);
        chk("R7", "latency", cyc - e.stamp, 4);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R7 watchdog got=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; lo_stb = 1'b0; hi_stb = 1'b0;
    front_byte = '0; back_byte = '0;
    repeat (3) @(negedge clk);
    chk("R9", "out_vld in reset", int'(out_vld), 0);
    chk("R9", "cov in reset", int'(cov), 0);
    chk("R9", "near_bk in reset", int'(near_bk), 0);
    rst = 1'b0;
    idle(2);
    chk("R9", "out_vld after reset", int'(out_vld), 0);

    // R6 unanimous corners
    send(pack4(100, 100, 100, 100), pack4(200, 200, 200, 200), "R6");
    idle(3);
    send(pack4(500, 400, 300, 200), pack4(-5, -6, -7, -8), "R6");
    idle(3);
    // R2 ties count for the front
    send(pack4(7, 7, 7, 7), pack4(7, 7, 7, 7), "R2");
    idle(2);
    // R2 full-range difference must not wrap
    send(pack4(-32768, 32767, -32768, 32767), pack4(32767, -32768, 32767, -32768), "R2");
    idle(2);
    send(pack4(-32768, 0, 1, -1), pack4(32767, 0, 0, 0), "R2");
    idle(2);
    // R1 borrow across the byte boundary
    send(pack4(16'h00FF, 16'h0100, 16'h7F00, 16'hFF00),
         pack4(16'h0100, 16'h00FF, 16'h7EFF, 16'hFEFF), "R1");
    idle(2);
    // R5 one front corner only
    send(pack4(0, 0, 0, 0), pack4(10, -1, -1, -1), "R5");
    idle(2);
    // R3 checkerboard: edges cancel to zero
    send(pack4(0, 0, 0, 0), pack4(5, -5, 5, -5), "R3");
    idle(2);
    send(pack4(0, 0, 0, 0), pack4(3, 3, -4, -4), "R3");
    idle(2);
    // R4 centre decided by the total
    send(pack4(0, 0, 0, 0), pack4(10, -3, -3, -3), "R4");
    idle(2);
    send(pack4(0, 0, 0, 0), pack4(-10, 3, 3, 3), "R4");
    idle(2);

    // R5 random, narrow spread with gaps
    for (int i = 0; i < 40; i++) begin
      logic [63:0] fv, bv;
      for (int k = 0; k < 4; k++) begin
        fv[k*16 +: 16] = 16'($urandom_range(0, 20)) - 16'd10;
        bv[k*16 +: 16] = 16'($urandom_range(0, 20)) - 16'd10;
      end
      send(fv, bv, "R5");
      idle(i % 3);
    end
    // R8 back to back, wide and narrow mixed
    for (int i = 0; i < 60; i++) begin
      logic [63:0] fv, bv;
      for (int k = 0; k < 4; k++) begin
        if (i % 2 == 0) begin
          fv[k*16 +: 16] = 16'($urandom);
          bv[k*16 +: 16] = 16'($urandom);
        end else begin
          fv[k*16 +: 16] = 16'($urandom_range(0, 8)) + 16'h00FC;
          bv[k*16 +: 16] = 16'($urandom_range(0, 8)) + 16'h00FC;
        end
      end
      send(fv, bv, "R8");
    end
    idle(10);
    chk("R7", "pending results", q.size(), 0);
    chk("R7", "out_vld idle", int'(out_vld), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule